// File: doc/BRIEF.md
# CAN Transmit Dominant Timeout Guard

This block sits in the transmit path between a CAN protocol controller and the bus driver stage. It takes the serial transmit bit from the controller, where low means dominant and high means recessive. It then produces two signals for the analog driver: a driver enable and a dominant-drive request. A transmit input stuck low, an over-temperature indication or a low supply voltage must never hold the bus dominant. The guard enforces this.

Three fault sources can switch the driver off. The first is an internal dominant-duration timer. The other two are digital flags from an external temperature sensor and an external supply comparator. Each fault is held in a latch, and every latch follows one release rule. A latch clears only on a clock edge where its cause is absent and the transmit input is high. A stuck-low controller therefore stays blocked until it lets go of the line. The supply fault also needs the supply to stay good for a set number of cycles before it may release. The timeout length and the recovery delay are parameters counted in clock cycles, and each fault has its own status output. A standby input turns the driver off without latching anything.

Top module: `can_txd_guard`

## Requirements
- R1: After reset, all three fault status outputs are 0, and the driver enable is 1 when standby is low.
- R2: While the driver is enabled, the dominant request equals the inverse of the transmit input (low input gives dominant, high gives recessive). Outside that state it is 0.
- R3: While standby is high, the driver enable and the dominant request are both 0. Standby sets no fault.
- R4: When the transmit input is sampled low on TIMEOUT_CYC consecutive rising edges, the dominant-timeout fault sets on the last of those edges. The dominant request is therefore high for exactly TIMEOUT_CYC clock periods of one continuous low.
- R5: A single high sample of the transmit input resets the dominant timer. A low that follows starts a full new TIMEOUT_CYC window.
- R6: The dominant timer saturates and does not wrap. With the input held low, the timeout fault stays set and the request stays 0 for any length of low.
- R7: The timeout fault clears on the first edge at which the transmit input is sampled high. After that, a low input again produces a dominant request.
- R8: The thermal fault sets on any edge where the thermal input is high. It clears only on an edge where the thermal input is low and the transmit input is high. While it is set, the driver enable is 0.
- R9: The undervoltage fault sets on any edge where the undervoltage input is high. It clears only on an edge where the undervoltage input is low, the transmit input is high, and the undervoltage input was low on at least RECOVER_CYC preceding edges. With the input held high, that is the (RECOVER_CYC+1)-th edge after the undervoltage input falls.
- R10: Each fault status output reflects only its own cause. A thermal or undervoltage event leaves the other status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txd_i | input | 1 | Transmit bit from the protocol controller; 0 = dominant |
| standby_i | input | 1 | Low-power mode; driver off while high |
| thermal_i | input | 1 | Over-temperature flag from the sensor |
| undervolt_i | input | 1 | Low-supply flag from the comparator |
| drv_en_o | output | 1 | Driver stage enable |
| drv_dom_o | output | 1 | Drive the bus dominant |
| flt_dom_o | output | 1 | Dominant-timeout fault status |
| flt_hot_o | output | 1 | Thermal fault status |
| flt_uv_o | output | 1 | Undervoltage fault status |

## Verification
The hardest state to reach is the undervoltage release boundary. The fault can only clear after exactly the required run of good-supply edges, and only if the transmit input is high at that moment. Random traffic seldom holds the supply good long enough while the transmit line happens to be high. A directed sequence therefore drops the flag and counts edges until release. Randomised runs of low and high transmit bits of varied length then push the dominant timer across its terminal count many times, including while other faults or standby are active.

// File: rtl/can_guard_pkg.sv
package can_guard_pkg;
  localparam int FLT_DOM = 0;
  localparam int FLT_HOT = 1;
  localparam int FLT_UV  = 2;
  localparam int NUM_FLT = 3;
endpackage

// File: rtl/can_dom_timer.sv
module can_dom_timer #(
  parameter int unsigned TIMEOUT_CYC = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txd_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);
  localparam logic [CW-1:0] LAST  = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (txd_i)       cnt_q <= '0;
    else if (cnt_q < LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  // current low sample completes the window
  assign expire_o = !txd_i && (cnt_q >= LAST);

  AST_TMR_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT); // R6
  AST_TMR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txd_i |=> (cnt_q == '0)); // R5
endmodule

// File: rtl/can_fault_latch.sv
module can_fault_latch #(
  parameter int unsigned REL_DELAY = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cause_i,
  input  logic txd_i,
  output logic flt_o
);
  logic flt_q;
  logic quiet_ok;

  generate
    if (REL_DELAY == 0) begin : g_nodly
      assign quiet_ok = 1'b1;
    end else begin : g_dly
      localparam int unsigned QW = $clog2(REL_DELAY + 1);
      localparam logic [QW-1:0] QLIM = QW'(REL_DELAY);
      logic [QW-1:0] quiet_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            quiet_q <= '0;
        else if (cause_i)       quiet_q <= '0;
        else if (quiet_q < QLIM) quiet_q <= quiet_q + 1'b1;
      end

      assign quiet_ok = (quiet_q >= QLIM);

      AST_QUIET_BEFORE_REL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(flt_q) |-> ($past(quiet_q) >= QLIM)); // R9
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                flt_q <= 1'b0;
    else if (cause_i)           flt_q <= 1'b1;
    else if (txd_i && quiet_ok) flt_q <= 1'b0;
  end

  assign flt_o = flt_q;

  AST_CAUSE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_i |=> flt_q); // R4
  AST_REL_NEEDS_TXD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flt_q) |-> ($past(txd_i) && !$past(cause_i))); // R7
endmodule

// File: rtl/can_txd_guard.sv
module can_txd_guard
  import can_guard_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 50000,
  parameter int unsigned RECOVER_CYC = 550
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txd_i,
  input  logic standby_i,
  input  logic thermal_i,
  input  logic undervolt_i,
  output logic drv_en_o,
  output logic drv_dom_o,
  output logic flt_dom_o,
  output logic flt_hot_o,
  output logic flt_uv_o
);
  logic               dom_expire;
  logic [NUM_FLT-1:0] cause_vec;
  logic [NUM_FLT-1:0] flt_vec;

  can_dom_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .txd_i    (txd_i),
    .expire_o (dom_expire)
  );

  always_comb begin
    cause_vec          = '0;
    cause_vec[FLT_DOM] = dom_expire;
    cause_vec[FLT_HOT] = thermal_i;
    cause_vec[FLT_UV]  = undervolt_i;
  end

  for (genvar g = 0; g < NUM_FLT; g++) begin : g_flt
    localparam int unsigned DLY = (g == FLT_UV) ? RECOVER_CYC : 0;
    can_fault_latch #(.REL_DELAY(DLY)) u_latch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cause_i (cause_vec[g]),
      .txd_i   (txd_i),
      .flt_o   (flt_vec[g])
    );
  end

  assign drv_en_o  = !standby_i && !(|flt_vec);
  assign drv_dom_o = drv_en_o && !txd_i;
  assign flt_dom_o = flt_vec[FLT_DOM];
  assign flt_hot_o = flt_vec[FLT_HOT];
  assign flt_uv_o  = flt_vec[FLT_UV];

  AST_HOT_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thermal_i |=> !drv_dom_o); // R8
  AST_UV_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undervolt_i |=> !drv_en_o); // R9
  AST_EXPIRE_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dom_expire |=> !drv_dom_o); // R4
endmodule

// File: tb/can_txd_guard_tb_top.sv
module can_txd_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 8;
  localparam int REC = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic txd = 1'b1, sb = 1'b0, hot = 1'b0, uv = 1'b0;
  logic en, dom, f_dom, f_hot, f_uv;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_txd_guard #(.TIMEOUT_CYC(TMO), .RECOVER_CYC(REC)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .txd_i(txd), .standby_i(sb),
    .thermal_i(hot), .undervolt_i(uv),
    .drv_en_o(en), .drv_dom_o(dom),
    .flt_dom_o(f_dom), .flt_hot_o(f_hot), .flt_uv_o(f_uv)
  );

  // behavioural expectation from the requirements
  int m_cnt, m_quiet;
  bit m_fd, m_fh, m_fu;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_quiet = 0; m_fd = 0; m_fh = 0; m_fu = 0;
    end else begin
      if (!txd && m_cnt + 1 >= TMO) m_fd = 1;        // R4
      else if (txd) m_fd = 0;                        // R7
      m_cnt = txd ? 0 : ((m_cnt < TMO) ? m_cnt + 1 : TMO);
      if (hot) m_fh = 1; else if (txd) m_fh = 0;     // R8
      if (uv) m_fu = 1; else if (txd && m_quiet >= REC) m_fu = 0; // R9
      m_quiet = uv ? 0 : ((m_quiet < REC) ? m_quiet + 1 : REC);
    end
  end

  function automatic int exp_en();
    return int'(!sb && !(m_fd || m_fh || m_fu));
  endfunction
  function automatic int exp_dom();
    return int'(exp_en() != 0 && !txd);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  int last_dom;
  task automatic cyc(input logic t, input logic h, input logic u, input logic s);
    txd = t; hot = h; uv = u; sb = s;
    #(CLK_PERIOD/4);
    chk("R2 drv_dom", int'(dom), exp_dom());
    chk("R3 drv_en", int'(en), exp_en());
    chk("R4 flt_dom", int'(f_dom), int'(m_fd));
    chk("R8 flt_hot", int'(f_hot), int'(m_fh));
    chk("R9 flt_uv", int'(f_uv), int'(m_fu));
    last_dom = int'(dom);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int width, k;
    int run_left;
    logic run_val;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk("R1 flt_dom", int'(f_dom), 0);
    chk("R1 flt_hot", int'(f_hot), 0);
    chk("R1 flt_uv", int'(f_uv), 0);
    chk("R1 drv_en", int'(en), 1);
    @(negedge clk);

    // R4 dominant width of one continuous low
    width = 0;
    for (int i = 0; i < TMO + 3; i++) begin
      cyc(1'b0, 1'b0, 1'b0, 1'b0);
      width += last_dom;
    end
    chk("R4 dominant width", width, TMO);
    // R6 saturation: still blocked long after
    for (int i = 0; i < 3 * TMO; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R6 flt held", int'(f_dom), 1);
    chk("R6 dom blocked", int'(dom), 0);
    // R7 release on high sample
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R7 flt cleared", int'(f_dom), 0);
    txd = 1'b0; #1;
    chk("R7 dom again", int'(dom), 1);
    cyc(1'b1, 1'b0, 1'b0, 1'b0);

    // R5 one high sample restarts the window
    for (int i = 0; i < TMO - 1; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < TMO - 1; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R5 no timeout", int'(f_dom), 0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0);

    // R8 thermal hold while txd low, release with txd high
    cyc(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R8 set", int'(f_hot), 1);
    chk("R10 uv untouched", int'(f_uv), 0);
    chk("R10 dom untouched", int'(f_dom), 0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 held txd low", int'(f_hot), 1);
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R8 released", int'(f_hot), 0);

    // R9 recovery edge count
    cyc(1'b1, 1'b0, 1'b1, 1'b0);
    chk("R9 set", int'(f_uv), 1);
    chk("R10 hot untouched", int'(f_hot), 0);
    k = 0;
    for (int i = 0; i < 20; i++) begin
      cyc(1'b1, 1'b0, 1'b0, 1'b0);
      k++;
      if (!f_uv) break;
    end
    chk("R9 recovery edges", k, REC + 1);

    // R3 standby
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    txd = 1'b0; #1;
    chk("R3 dom off", int'(dom), 0);
    chk("R3 no fault", int'(f_dom | f_hot | f_uv), 0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0);

    // random runs
    run_left = 0; run_val = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      if (run_left == 0) begin
        run_val = ~run_val;
        run_left = 1 + int'($urandom_range(0, 2 * TMO));
      end
      run_left--;
      cyc(run_val, ($urandom_range(0, 39) == 0), ($urandom_range(0, 49) == 0),
          ($urandom_range(0, 29) == 0));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule